// File: doc/BRIEF.md
# Microcontroller Sleep Mode Controller

This block decides when a small 8-bit microcontroller core sleeps and what wakes it. The core's decoder pulses a strobe when it executes a sleep instruction. The block looks at a sleep-enable bit and a mode bit from a control register in the same cycle. The mode bit picks between two low-power states. In the light state, Idle, only the CPU clock stops. In the deep state, Power-down, the CPU clock, the peripheral clock and the main oscillator all stop.

Three kinds of event wake the core. The first is an enabled interrupt. The second is a level or pin-change condition, which must stay present long enough to pass a reset-delay check. The third is a reset request from the external reset pin or from an enabled watchdog. After an interrupt wake, the CPU stays halted for a fixed number of cycles before it resumes. After a reset wake, the CPU restarts through the reset vector. When the core resumes, a one-cycle `resume` pulse marks the event, and `wake_vec_sel` tells the core which vector to take.

The controller only gates clocks. It never writes core state, so the register file and the I/O registers keep their contents across a sleep.

Top module: `sleep_ctl`

## Requirements
- R1: A strobe on `sleep_stb` in Run puts the core to sleep only if `sleep_en` is 1 in that same cycle. When `sleep_en` is 0, the strobe does nothing: all three clock enables stay 1.
- R2: A qualifying strobe with `sleep_mode`=0 enters Idle from the next cycle. In Idle, `cpu_clk_en`=0, `periph_clk_en`=1 and `osc_en`=1.
- R3: A qualifying strobe with `sleep_mode`=1 enters Power-down from the next cycle. In Power-down, `cpu_clk_en`, `periph_clk_en` and `osc_en` are all 0.
- R4: In Idle, any set bit of `irq_req`, or `ext_level` or `pin_chg` high, moves the controller to the halt delay at the next clock edge.
- R5: In Power-down, `irq_req` is ignored. `ext_level` or `pin_chg` causes a wake only after one of them has been high for QUAL_CYCLES consecutive cycles (16 by default). A gap resets the count, and the core stays asleep.
- R6: The halt delay lasts HALT_CYCLES cycles (4 by default). During the delay, `cpu_clk_en`=0 and the other two enables are 1. In the first Run cycle after the delay, `resume`=1 and `wake_vec_sel`=0 (interrupt vector).
- R7: In Idle, Power-down or the halt delay, `ext_rst`=1, or `wdt_timeout`=1 together with `wdt_en`=1, enters a one-cycle reset-wake state. In that state, `cpu_clk_en`=0 and `osc_en`=1. The next cycle is Run with `resume`=1 and `wake_vec_sel`=1 (reset vector). A reset request beats any interrupt or qualified wake in the same cycle.
- R8: When `wdt_en`=0, `wdt_timeout` has no effect in any sleep state.
- R9: A sleep strobe outside Run is ignored, and a reset request in Run is ignored: `resume` stays 0.
- R10: While `rst_n`=0, and after it is released, the controller is in Run with all enables 1, `resume`=0 and `wake_vec_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| sleep_stb | input | 1 | Pulse when the sleep instruction executes |
| sleep_en | input | 1 | Sleep-enable bit of the control register |
| sleep_mode | input | 1 | 0 selects Idle, 1 selects Power-down |
| irq_req | input | IRQ_W | Enabled, already-masked interrupt requests |
| ext_level | input | 1 | Enabled level interrupt on the external pin |
| pin_chg | input | 1 | Enabled pin-change condition |
| ext_rst | input | 1 | External reset request |
| wdt_timeout | input | 1 | Watchdog timeout |
| wdt_en | input | 1 | Watchdog enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Timer, watchdog and interrupt-logic clock enable |
| osc_en | output | 1 | Main oscillator enable |
| resume | output | 1 | One-cycle pulse when the CPU restarts after a wake |
| wake_vec_sel | output | 1 | 0 = interrupt vector, 1 = reset vector |

## Verification
Two events can arrive in the same cycle, and both can end a sleep: a reset request and an interrupt wake. The interrupt wake can be an immediate wake in Idle, or the final count of a qualified level in Power-down. The bench forces both collisions directly. It raises `wdt_timeout` with `wdt_en` set in the same cycle as an interrupt in Idle. It asserts `ext_rst` on the sixteenth cycle of a held pin change in Power-down. In each case the pass condition is that the one-cycle reset-wake state appears and the resume pulse carries the reset vector. The random phase mixes these sources freely and compares every cycle against a bench model.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

   typedef enum logic [2:0] {
      ST_RUN    = 3'd0,
      ST_IDLE   = 3'd1,
      ST_PDOWN  = 3'd2,
      ST_WDELAY = 3'd3,
      ST_RWAKE  = 3'd4
   } slp_state_t;

   typedef struct packed {
      logic cpu;
      logic periph;
      logic osc;
   } clk_gate_t;

   // Clock gating per state: only Run clocks the CPU, only Power-down stops the oscillator
   function automatic clk_gate_t gates_for(slp_state_t s);
      clk_gate_t g;
      case (s)
         ST_RUN:   g = '{cpu: 1'b1, periph: 1'b1, osc: 1'b1};
         ST_PDOWN: g = '{cpu: 1'b0, periph: 1'b0, osc: 1'b0};
         default:  g = '{cpu: 1'b0, periph: 1'b1, osc: 1'b1};
      endcase
      return g;
   endfunction

endpackage

// File: rtl/sleep_wake_src.sv
module sleep_wake_src #(
   parameter int IRQ_W = 4
) (
   input  logic [IRQ_W-1:0] irq_req,
   input  logic             ext_level,
   input  logic             pin_chg,
   input  logic             ext_rst,
   input  logic             wdt_timeout,
   input  logic             wdt_en,
   output logic             rst_wake,
   output logic             idle_wake,
   output logic             pd_cond
);

   logic any_irq;

   generate
      if (IRQ_W < 1) begin : g_bad_irq
         $error("sleep_wake_src: IRQ_W must be at least 1");
      end
      if (IRQ_W == 1) begin : g_one_irq
         assign any_irq = irq_req[0];
      end else begin : g_many_irq
         assign any_irq = |irq_req;
      end
   endgenerate

   // Reset requests: pin reset always, watchdog only when enabled
   assign rst_wake  = ext_rst | (wdt_timeout & wdt_en);
   // Asynchronous sources alive in Power-down
   assign pd_cond   = ext_level | pin_chg;
   // Idle keeps the interrupt logic clocked, so every enabled source counts
   assign idle_wake = any_irq | pd_cond;

endmodule

// File: rtl/sleep_cnt_qual.sv
module sleep_cnt_qual #(
   parameter int QUAL_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cond,
   output logic fire
);

   generate
      if (QUAL_CYCLES < 1) begin : g_bad_qual
         $error("sleep_cnt_qual: QUAL_CYCLES must be at least 1");
      end
      if (QUAL_CYCLES == 1) begin : g_direct
         assign fire = cond & ~clr;
      end else begin : g_counted
         localparam int CW = $clog2(QUAL_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);
         logic [CW-1:0] cnt;

         assign fire = ~clr & cond & (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (clr || !cond || fire) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sleep_halt_tmr.sv
module sleep_halt_tmr #(
   parameter int HALT_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   generate
      if (HALT_CYCLES < 1) begin : g_bad_halt
         $error("sleep_halt_tmr: HALT_CYCLES must be at least 1");
      end
      if (HALT_CYCLES == 1) begin : g_single
         assign done = run;
      end else begin : g_counted
         localparam int CW = $clog2(HALT_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(HALT_CYCLES - 1);
         logic [CW-1:0] cnt;

         assign done = run & (cnt == LAST);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run || done) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/sleep_ctl.sv
module sleep_ctl
   import sleep_pkg::*;
#(
   parameter int IRQ_W       = 4,
   parameter int HALT_CYCLES = 4,
   parameter int QUAL_CYCLES = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep_stb,
   input  logic             sleep_en,
   input  logic             sleep_mode,
   input  logic [IRQ_W-1:0] irq_req,
   input  logic             ext_level,
   input  logic             pin_chg,
   input  logic             ext_rst,
   input  logic             wdt_timeout,
   input  logic             wdt_en,
   output logic             cpu_clk_en,
   output logic             periph_clk_en,
   output logic             osc_en,
   output logic             resume,
   output logic             wake_vec_sel
);

   slp_state_t state, state_nx;
   clk_gate_t  gates;
   logic       rst_wake, idle_wake, pd_cond;
   logic       qual_fire, halt_done;
   logic       resume_nx, vec_nx;

   sleep_wake_src #(.IRQ_W(IRQ_W)) u_src (
      .irq_req     (irq_req),
      .ext_level   (ext_level),
      .pin_chg     (pin_chg),
      .ext_rst     (ext_rst),
      .wdt_timeout (wdt_timeout),
      .wdt_en      (wdt_en),
      .rst_wake    (rst_wake),
      .idle_wake   (idle_wake),
      .pd_cond     (pd_cond)
   );

   sleep_cnt_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (state != ST_PDOWN),
      .cond  (pd_cond),
      .fire  (qual_fire)
   );

   sleep_halt_tmr #(.HALT_CYCLES(HALT_CYCLES)) u_halt (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_WDELAY),
      .done  (halt_done)
   );

   // Next state: reset requests win over every interrupt-type wake
   always_comb begin
      state_nx  = state;
      resume_nx = 1'b0;
      case (state)
         ST_RUN: begin
            if (sleep_stb && sleep_en) begin
               state_nx = sleep_mode ? ST_PDOWN : ST_IDLE;
            end
         end
         ST_IDLE: begin
            if (rst_wake)       state_nx = ST_RWAKE;
            else if (idle_wake) state_nx = ST_WDELAY;
         end
         ST_PDOWN: begin
            if (rst_wake)       state_nx = ST_RWAKE;
            else if (qual_fire) state_nx = ST_WDELAY;
         end
         ST_WDELAY: begin
            if (rst_wake) begin
               state_nx = ST_RWAKE;
            end else if (halt_done) begin
               state_nx  = ST_RUN;
               resume_nx = 1'b1;
            end
         end
         ST_RWAKE: begin
            state_nx  = ST_RUN;
            resume_nx = 1'b1;
         end
         default: state_nx = ST_RUN;
      endcase
   end

   // Vector choice is latched when the wake path is chosen
   always_comb begin
      vec_nx = wake_vec_sel;
      if (state_nx == ST_RWAKE)                            vec_nx = 1'b1;
      else if (state_nx == ST_WDELAY && state != ST_WDELAY) vec_nx = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_RUN;
         resume       <= 1'b0;
         wake_vec_sel <= 1'b0;
      end else begin
         state        <= state_nx;
         resume       <= resume_nx;
         wake_vec_sel <= vec_nx;
      end
   end

   assign gates         = gates_for(state);
   assign cpu_clk_en    = gates.cpu;
   assign periph_clk_en = gates.periph;
   assign osc_en        = gates.osc;

endmodule

// File: rtl/sleep_ctl_chk.sv
module sleep_ctl_chk
   import sleep_pkg::*;
#(
   parameter int HALT_CYCLES = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sleep_stb,
   input logic       sleep_en,
   input logic       sleep_mode,
   input logic       ext_level,
   input logic       pin_chg,
   input logic       rst_wake,
   input slp_state_t state,
   input logic       cpu_clk_en,
   input logic       periph_clk_en,
   input logic       osc_en,
   input logic       resume,
   input logic       wake_vec_sel
);

   int wd_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  wd_cnt <= 0;
      else if (state == ST_WDELAY) wd_cnt <= wd_cnt + 1;
      else                         wd_cnt <= 0;
   end

   assert_sleep_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && sleep_stb && !sleep_en) |=> cpu_clk_en);

   assert_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && sleep_stb && sleep_en && !sleep_mode) |=>
      (!cpu_clk_en && periph_clk_en && osc_en));

   assert_pdown_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && sleep_stb && sleep_en && sleep_mode) |=>
      (!cpu_clk_en && !periph_clk_en && !osc_en));

   assert_osc_off_implies_all_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> (!cpu_clk_en && !periph_clk_en));

   assert_pdown_irq_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_PDOWN && !rst_wake && !ext_level && !pin_chg) |=> (state == ST_PDOWN));

   assert_halt_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WDELAY) |-> (wd_cnt < HALT_CYCLES));

   assert_resume_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      resume |=> !resume);

   assert_resume_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      resume |-> cpu_clk_en);

   assert_reset_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_RUN && state != ST_RWAKE && rst_wake) |=>
      (state == ST_RWAKE && wake_vec_sel && !cpu_clk_en));

   assert_run_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !(sleep_stb && sleep_en)) |=> (state == ST_RUN && !resume));

endmodule

bind sleep_ctl sleep_ctl_chk #(.HALT_CYCLES(HALT_CYCLES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .sleep_stb     (sleep_stb),
   .sleep_en      (sleep_en),
   .sleep_mode    (sleep_mode),
   .ext_level     (ext_level),
   .pin_chg       (pin_chg),
   .rst_wake      (rst_wake),
   .state         (state),
   .cpu_clk_en    (cpu_clk_en),
   .periph_clk_en (periph_clk_en),
   .osc_en        (osc_en),
   .resume        (resume),
   .wake_vec_sel  (wake_vec_sel)
);

// File: tb/sleep_ctl_bench.sv
`timescale 1ns/1ps
module sleep_ctl_bench;

   localparam int IRQ_W = 4;
   localparam int HALT  = 4;
   localparam int QUAL  = 16;

   // bench-side model state codes
   localparam int M_RUN = 0, M_IDLE = 1, M_PD = 2, M_WD = 3, M_RW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_stb = 0, sleep_en = 0, sleep_mode = 0;
   logic [IRQ_W-1:0] irq_req = '0;
   logic ext_level = 0, pin_chg = 0, ext_rst = 0, wdt_timeout = 0, wdt_en = 0;
   logic cpu_clk_en, periph_clk_en, osc_en, resume, wake_vec_sel;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 0;

   int m_st, m_q, m_h;
   bit m_vec, m_res;

   always #10 clk = ~clk;

   sleep_ctl #(.IRQ_W(IRQ_W), .HALT_CYCLES(HALT), .QUAL_CYCLES(QUAL)) u_sleep_ctl (
      .clk(clk), .rst_n(rst_n), .sleep_stb(sleep_stb), .sleep_en(sleep_en),
      .sleep_mode(sleep_mode), .irq_req(irq_req), .ext_level(ext_level),
      .pin_chg(pin_chg), .ext_rst(ext_rst), .wdt_timeout(wdt_timeout),
      .wdt_en(wdt_en), .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en),
      .osc_en(osc_en), .resume(resume), .wake_vec_sel(wake_vec_sel)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int s);
      case (s)
         M_IDLE:  return "R2";
         M_PD:    return "R3";
         M_WD:    return "R6";
         M_RW:    return "R7";
         default: return "R1";
      endcase
   endfunction

   function automatic int exp_gates(input int s);
      // packed {cpu, periph, osc}
      case (s)
         M_RUN:   return 7;
         M_PD:    return 0;
         default: return 3;
      endcase
   endfunction

   task automatic model_step();
      bit rw, iw, pc;
      rw = ext_rst | (wdt_timeout & wdt_en);
      pc = ext_level | pin_chg;
      iw = (irq_req != '0) | pc;
      m_res = 0;
      case (m_st)
         M_RUN: if (sleep_stb && sleep_en) m_st = sleep_mode ? M_PD : M_IDLE;
         M_IDLE: begin
            if (rw)      begin m_st = M_RW; m_vec = 1; end
            else if (iw) begin m_st = M_WD; m_vec = 0; m_h = 0; end
         end
         M_PD: begin
            if (rw) begin m_st = M_RW; m_vec = 1; end
            else if (pc) begin
               if (m_q == QUAL - 1) begin m_st = M_WD; m_vec = 0; m_h = 0; end
               else m_q++;
            end else m_q = 0;
         end
         M_WD: begin
            if (rw) begin m_st = M_RW; m_vec = 1; end
            else if (m_h == HALT - 1) begin m_st = M_RUN; m_res = 1; end
            else m_h++;
         end
         default: begin m_st = M_RUN; m_res = 1; end
      endcase
      if (m_st != M_PD) m_q = 0;
      if (m_st != M_WD) m_h = 0;
   endtask

   // one clock: model follows the sampled inputs, then every output is compared
   task automatic cyc();
      int g;
      @(posedge clk);
      model_step();
      #1;
      g = {cpu_clk_en, periph_clk_en, osc_en};
      chk(g == exp_gates(m_st), tag_of(m_st), "clock enables", g, exp_gates(m_st));
      chk(resume == m_res, "R6", "resume", resume, m_res);
      chk(wake_vec_sel == m_vec, "R7", "wake_vec_sel", wake_vec_sel, m_vec);
   endtask

   task automatic clear_in();
      sleep_stb = 0; irq_req = '0; ext_level = 0; pin_chg = 0;
      ext_rst = 0; wdt_timeout = 0;
   endtask

   task automatic go_sleep(input bit mode);
      sleep_en = 1; sleep_mode = mode; sleep_stb = 1;
      cyc();
      sleep_stb = 0;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL R10 watchdog expired: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      int cnt;
      void'($urandom(32'd20240611));
      m_st = M_RUN; m_q = 0; m_h = 0; m_vec = 0; m_res = 0;
      repeat (3) @(posedge clk);
      #1;
      chk({cpu_clk_en, periph_clk_en, osc_en} == 3'b111 && !resume && !wake_vec_sel,
          "R10", "state in reset", {cpu_clk_en, periph_clk_en, osc_en}, 7);
      rst_n = 1;
      cyc();

      // R1: strobe with sleep disabled is a no-op
      sleep_en = 0; sleep_stb = 1; sleep_mode = 1;
      cyc();
      sleep_stb = 0;
      chk(cpu_clk_en && osc_en, "R1", "disabled sleep ignored", cpu_clk_en, 1);

      // R9: reset request in Run has no effect
      ext_rst = 1; cyc(); ext_rst = 0; cyc();
      chk(!resume && cpu_clk_en, "R9", "reset in run ignored", resume, 0);

      // R2 then R9 (strobe while idle) then R4/R6
      go_sleep(0);
      chk(!cpu_clk_en && periph_clk_en && osc_en, "R2", "idle gates",
          {cpu_clk_en, periph_clk_en, osc_en}, 3);
      sleep_mode = 1; sleep_stb = 1; cyc(); sleep_stb = 0;
      chk(osc_en == 1, "R9", "strobe in idle ignored", osc_en, 1);
      irq_req = 4'b0100; cyc(); irq_req = '0;
      chk(!cpu_clk_en && periph_clk_en, "R4", "idle irq wake to halt", cpu_clk_en, 0);
      cnt = 1;
      while (!cpu_clk_en && cnt < 50) begin cyc(); if (!cpu_clk_en) cnt++; end
      chk(cnt == HALT, "R6", "halt cycles", cnt, HALT);
      chk(resume && !wake_vec_sel, "R6", "resume to irq vector", resume, 1);

      // R3, R5, R8
      go_sleep(1);
      chk(!osc_en && !periph_clk_en && !cpu_clk_en, "R3", "pdown gates", osc_en, 0);
      irq_req = '1; repeat (3) cyc(); irq_req = '0;
      chk(!osc_en, "R5", "irq ignored in pdown", osc_en, 0);
      wdt_en = 0; wdt_timeout = 1; cyc(); wdt_timeout = 0; cyc();
      chk(!osc_en, "R8", "disabled watchdog ignored", osc_en, 0);
      ext_level = 1; repeat (5) cyc(); ext_level = 0; cyc();
      chk(!osc_en, "R5", "short level no wake", osc_en, 0);
      pin_chg = 1; cnt = 0;
      while (!osc_en && cnt < 100) begin cyc(); cnt++; end
      pin_chg = 0;
      chk(cnt == QUAL, "R5", "qualify length", cnt, QUAL);
      repeat (HALT) cyc();
      chk(resume && !wake_vec_sel, "R6", "pdown resume irq vector", resume, 1);

      // R7: external reset in power-down
      go_sleep(1);
      ext_rst = 1; cyc(); ext_rst = 0;
      chk(!cpu_clk_en && osc_en, "R7", "reset-wake gates", osc_en, 1);
      cyc();
      chk(resume && wake_vec_sel && cpu_clk_en, "R7", "reset vector resume", wake_vec_sel, 1);

      // R7: watchdog and irq in the same idle cycle
      go_sleep(0);
      wdt_en = 1; wdt_timeout = 1; irq_req = 4'b0001; cyc(); clear_in();
      cyc();
      chk(resume && wake_vec_sel, "R7", "reset beats irq in idle", wake_vec_sel, 1);

      // R7: reset on the final qualification cycle
      go_sleep(1);
      pin_chg = 1; repeat (QUAL - 1) cyc();
      ext_rst = 1; cyc(); clear_in();
      cyc();
      chk(resume && wake_vec_sel, "R7", "reset beats qualified wake", wake_vec_sel, 1);

      // random phase
      wdt_en = 0;
      for (int i = 0; i < 6000; i++) begin
         sleep_stb  = ($urandom % 8) == 0;
         sleep_en   = ($urandom % 4) != 0;
         sleep_mode = $urandom % 2;
         irq_req    = (($urandom % 16) == 0) ? IRQ_W'($urandom) : '0;
         if (($urandom % 24) == 0) ext_level = ~ext_level;
         if (($urandom % 40) == 0) pin_chg = ~pin_chg;
         ext_rst     = ($urandom % 300) == 0;
         wdt_timeout = ($urandom % 150) == 0;
         if (($urandom % 50) == 0) wdt_en = ~wdt_en;
         cyc();
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule